// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns the current bus address of an 8-bit controller with a 16-bit address space into four chip-select outputs: a program-memory select, a general-purpose select and two I/O selects. Three byte-wide registers, written and read over a small register bus, set the decode. A control byte holds the enables, the I/O polarities, the overlap priority and the program window size. A base byte holds the start of the general window. A size byte holds the general window size and its enable.

The program window always ends at the top of the address space. A two-bit code sets it to 64, 32, 16 or 8 KB. The general window starts at a 1 KB-granular base, and its size runs from 1 KB to 64 KB. Base bits below the window size drop out of the compare. When both windows contain the address, the priority bit decides which select fires. The two I/O selects decode fixed 1 KB windows set by parameters, and each has its own polarity.

Any select whose enable is clear gives up its pin, so the pin can serve as general-purpose I/O. A select fires only while the bus-cycle strobe is high. The reset value of the program enable follows the operating mode.

Top module: `cs_decoder`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the control byte to 0x04 when mode_expanded is 1 and to 0x00 when it is 0. It sets the base byte and the size byte to 0x00.
- R2: Registers are selected by reg_addr: 0 is control, 1 is base, 2 is size, and 3 reads 0x00. A write with reg_we high takes effect at the next rising edge. reg_rdata is the stored value. Base bits 1:0 read 0. Size bits 7:4 read 0.
- R3: Control bit 1 is size A and bit 0 is size B. The program window for {A,B} is 00: 0x0000–0xFFFF, 01: 0x8000–0xFFFF, 10: 0xC000–0xFFFF, 11: 0xE000–0xFFFF.
- R4: Base bits 7:2 give start-address bits 15:10. Size bits 2:0 hold a code c, and the window is 2^(10+min(c,6)) bytes. Only address bits 15 down to 10+min(c,6) are compared with the base.
- R5: Control bit 3 is the priority bit. When both enabled windows match, a value of 0 fires cs_prog only, and a value of 1 fires cs_gp only.
- R6: Control bits 7/6 are the enable and polarity of I/O select 1, and bits 5/4 are the same for I/O select 2. Each I/O select matches a 1 KB window at parameter IO1_BASE or IO2_BASE. When enabled, its pin is at the polarity bit's value while active and at the inverse otherwise, so polarity 1 means active high.
- R7: When an I/O enable is 0, that select's pin output is 0 and its pin-own flag is 0.
- R8: While bus_valid is 0, cs_prog and cs_gp are 0 and every enabled I/O pin sits at its inactive level.
- R9: cs_prog and cs_gp are active high. Control bit 2 is the program enable and size bit 3 is the general enable. prog_pin_own and gp_pin_own follow these enables, and a disabled select never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_expanded | input | 1 | Operating mode, sets the program enable at reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| bus_addr | input | 16 | Current bus address |
| bus_valid | input | 1 | Valid bus-cycle strobe |
| cs_prog | output | 1 | Program-memory select, active high |
| cs_gp | output | 1 | General-purpose select, active high |
| cs_io1 | output | 1 | I/O select 1 pin level |
| cs_io2 | output | 1 | I/O select 2 pin level |
| prog_pin_own | output | 1 | Program select owns its pin |
| gp_pin_own | output | 1 | General select owns its pin |
| io1_pin_own | output | 1 | I/O select 1 owns its pin |
| io2_pin_own | output | 1 | I/O select 2 owns its pin |

## Verification
The bench builds the block with its default 16-bit address and 1 KB granule. It places IO1_BASE at 0x1000 and IO2_BASE at 0xE400, which lies inside every program window, so I/O decode is exercised while the program and general selects also fire. Under these parameters it sweeps all four program sizes, both priorities and all eight general size codes, including the clamped code 7. Each configuration sees 256 addresses that hit the first and last byte of every 1 KB block, so each window edge is sampled, with the strobe dropped on a fixed subset of them.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef struct packed {
    logic       io1_en;
    logic       io1_pol;
    logic       io2_en;
    logic       io2_pol;
    logic       gp_first;
    logic       prog_en;
    logic [1:0] prog_sz;
  } cs_ctrl_t;

  localparam int CTRL_W = $bits(cs_ctrl_t);

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_BASE  = 2'd1;
  localparam logic [1:0] RA_GSIZE = 2'd2;

  localparam int NUM_IO = 2;

endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GA_W   = 6,
  parameter int GSZ_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_expanded,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output cs_ctrl_t          ctrl,
  output logic [GA_W-1:0]   gp_base,
  output logic [GSZ_W-1:0]  gp_size,
  output logic              gp_en
);

  localparam int BASE_PAD = DATA_W - GA_W;
  localparam int SIZE_PAD = DATA_W - GSZ_W - 1;

  cs_ctrl_t           ctrl_q;
  logic [GA_W-1:0]    base_q;
  logic [GSZ_W-1:0]   size_q;
  logic               gen_q;

  logic wr_ctrl, wr_base, wr_size;
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_base = reg_we && (reg_addr == RA_BASE);
  assign wr_size = reg_we && (reg_addr == RA_GSIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q         <= '0;
      ctrl_q.prog_en <= mode_expanded;
      base_q         <= '0;
      size_q         <= '0;
      gen_q          <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= cs_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (wr_base) base_q <= reg_wdata[DATA_W-1 -: GA_W];
      if (wr_size) begin
        size_q <= reg_wdata[GSZ_W-1:0];
        gen_q  <= reg_wdata[GSZ_W];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      RA_BASE:  reg_rdata = {base_q, {BASE_PAD{1'b0}}};
      RA_GSIZE: reg_rdata = {{SIZE_PAD{1'b0}}, gen_q, size_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign gp_base = base_q;
  assign gp_size = size_q;
  assign gp_en   = gen_q;

  // R2: a write is visible in the stored state one edge later
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == cs_ctrl_t'($past(reg_wdata[CTRL_W-1:0]))));

  p_base_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> (base_q == $past(reg_wdata[DATA_W-1 -: GA_W])));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ctrl_q) && $stable(base_q) && $stable(size_q));

endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              GRAN_LOG2 = 10,
  parameter int              GSZ_W     = 3,
  parameter logic [ADDR_W-1:0] IO1_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] IO2_BASE = 16'h1400
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                prog_sz,
  input  logic [ADDR_W-GRAN_LOG2-1:0] gp_base,
  input  logic [GSZ_W-1:0]          gp_size,
  output logic                      prog_hit,
  output logic                      gp_hit,
  output logic [NUM_IO-1:0]         io_hit
);

  localparam int GA_W     = ADDR_W - GRAN_LOG2;
  localparam int MAX_CODE = GA_W;

  // Window at the top of memory: the top n address bits must all be one.
  function automatic logic top_window(input logic [ADDR_W-1:0] a,
                                      input logic [1:0] n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= ADDR_W - int'(n)) ok = ok & a[i];
    end
    return ok;
  endfunction

  // Low compare bit for a size code, clamped so the window never exceeds memory.
  function automatic int low_bit(input logic [GSZ_W-1:0] code);
    int c;
    c = int'(code);
    if (c > MAX_CODE) c = MAX_CODE;
    return GRAN_LOG2 + c;
  endfunction

  function automatic logic masked_eq(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input int lo);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= lo) ok = ok & (a[i] == b[i]);
    end
    return ok;
  endfunction

  logic [ADDR_W-1:0] gp_start;
  assign gp_start = {gp_base, {GRAN_LOG2{1'b0}}};

  assign prog_hit = top_window(addr, prog_sz);
  assign gp_hit   = masked_eq(addr, gp_start, low_bit(gp_size));

  for (genvar g = 0; g < NUM_IO; g++) begin : g_io
    localparam logic [ADDR_W-1:0] WBASE = (g == 0) ? IO1_BASE : IO2_BASE;
    assign io_hit[g] = masked_eq(addr, WBASE, GRAN_LOG2);
  end

  // R3: the smallest program window lies in the top eighth of memory
  p_prog_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_hit && prog_sz == 2'b11) |-> (&addr[ADDR_W-1 -: 3]));

  // R4: the smallest general window matches the full base field
  p_gp_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_hit && gp_size == '0) |-> (addr[ADDR_W-1:GRAN_LOG2] == gp_base));

endmodule

// File: rtl/cs_drive.sv
module cs_drive
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  cs_ctrl_t          ctrl,
  input  logic              gp_en,
  input  logic              prog_hit,
  input  logic              gp_hit,
  input  logic [NUM_IO-1:0] io_hit,
  output logic              cs_prog,
  output logic              cs_gp,
  output logic [NUM_IO-1:0] io_pin,
  output logic [NUM_IO-1:0] io_own,
  output logic              prog_own,
  output logic              gp_own
);

  logic              prog_req, gp_req, both_req;
  logic              prog_grant, gp_grant;
  logic [NUM_IO-1:0] io_en, io_pol, io_act;

  assign prog_req   = bus_valid && ctrl.prog_en && prog_hit;
  assign gp_req     = bus_valid && gp_en && gp_hit;
  assign both_req   = prog_req && gp_req;
  assign prog_grant = prog_req && !(both_req && ctrl.gp_first);
  assign gp_grant   = gp_req && !(both_req && !ctrl.gp_first);

  assign io_en  = {ctrl.io2_en, ctrl.io1_en};
  assign io_pol = {ctrl.io2_pol, ctrl.io1_pol};

  for (genvar g = 0; g < NUM_IO; g++) begin : g_pin
    assign io_act[g] = bus_valid && io_en[g] && io_hit[g];
    assign io_pin[g] = io_en[g] ? (io_act[g] ? io_pol[g] : !io_pol[g]) : 1'b0;
    assign io_own[g] = io_en[g];
  end

  assign cs_prog  = prog_grant;
  assign cs_gp    = gp_grant;
  assign prog_own = ctrl.prog_en;
  assign gp_own   = gp_en;

  // R5: overlap never fires both memory selects
  p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_prog && cs_gp));

  p_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (both_req && ctrl.gp_first) |-> (cs_gp && !cs_prog));

  // R8: no activity without the strobe
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!cs_prog && !cs_gp && io_act == '0));

  // R7: disabled I/O selects release their pins
  p_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.io1_en |-> (!io_pin[0] && !io_own[0]));

  // R6: an idle enabled I/O pin sits at the inverse of its polarity
  p_pol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_own[1] && !io_act[1]) |-> (io_pin[1] == !ctrl.io2_pol));

  // R9: a disabled memory select never fires
  p_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_own |-> !cs_prog) and (!gp_own |-> !cs_gp));

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                GRAN_LOG2 = 10,
  parameter int                GSZ_W     = 3,
  parameter logic [ADDR_W-1:0] IO1_BASE  = 16'h1000,
  parameter logic [ADDR_W-1:0] IO2_BASE  = 16'h1400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_expanded,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  output logic              cs_prog,
  output logic              cs_gp,
  output logic              cs_io1,
  output logic              cs_io2,
  output logic              prog_pin_own,
  output logic              gp_pin_own,
  output logic              io1_pin_own,
  output logic              io2_pin_own
);

  localparam int GA_W = ADDR_W - GRAN_LOG2;

  cs_ctrl_t          ctrl;
  logic [GA_W-1:0]   gp_base;
  logic [GSZ_W-1:0]  gp_size;
  logic              gp_en;
  logic              prog_hit, gp_hit;
  logic [NUM_IO-1:0] io_hit, io_pin, io_own;

  cs_regfile #(
    .DATA_W (DATA_W),
    .GA_W   (GA_W),
    .GSZ_W  (GSZ_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_expanded (mode_expanded),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ctrl          (ctrl),
    .gp_base       (gp_base),
    .gp_size       (gp_size),
    .gp_en         (gp_en)
  );

  cs_match #(
    .ADDR_W    (ADDR_W),
    .GRAN_LOG2 (GRAN_LOG2),
    .GSZ_W     (GSZ_W),
    .IO1_BASE  (IO1_BASE),
    .IO2_BASE  (IO2_BASE)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .prog_sz  (ctrl.prog_sz),
    .gp_base  (gp_base),
    .gp_size  (gp_size),
    .prog_hit (prog_hit),
    .gp_hit   (gp_hit),
    .io_hit   (io_hit)
  );

  cs_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .ctrl       (ctrl),
    .gp_en      (gp_en),
    .prog_hit   (prog_hit),
    .gp_hit     (gp_hit),
    .io_hit     (io_hit),
    .cs_prog    (cs_prog),
    .cs_gp      (cs_gp),
    .io_pin     (io_pin),
    .io_own     (io_own),
    .prog_own   (prog_pin_own),
    .gp_own     (gp_pin_own)
  );

  assign cs_io1      = io_pin[0];
  assign cs_io2      = io_pin[1];
  assign io1_pin_own = io_own[0];
  assign io2_pin_own = io_own[1];

endmodule

// File: tb/cs_decoder_tb.sv
module cs_decoder_tb;

  localparam logic [15:0] IO1_B = 16'h1000;
  localparam logic [15:0] IO2_B = 16'hE400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_expanded = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_addr = 16'd0;
  logic        bus_valid = 1'b0;
  logic cs_prog, cs_gp, cs_io1, cs_io2;
  logic prog_pin_own, gp_pin_own, io1_pin_own, io2_pin_own;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cs_decoder #(.IO1_BASE(IO1_B), .IO2_BASE(IO2_B)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_expanded(mode_expanded),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .cs_prog(cs_prog), .cs_gp(cs_gp), .cs_io1(cs_io1), .cs_io2(cs_io2),
    .prog_pin_own(prog_pin_own), .gp_pin_own(gp_pin_own),
    .io1_pin_own(io1_pin_own), .io2_pin_own(io2_pin_own)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic bit in_range(input int a, input int lo, input int span);
    return (a >= lo) && (a < lo + span);
  endfunction

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; mode_expanded = mode;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;

    // R1: reset values in both modes
    do_reset(1'b1);
    rd(2'd0, v); chk("R1 ctrl expanded", v, 8'h04);
    rd(2'd1, v); chk("R1 base", v, 8'h00);
    rd(2'd2, v); chk("R1 size", v, 8'h00);
    do_reset(1'b0);
    rd(2'd0, v); chk("R1 ctrl single", v, 8'h00);

    // R2: write timing and read-as-zero bits
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hA5;
    #1 chk("R2 before edge", reg_rdata, 8'h00);
    @(negedge clk);
    reg_we = 1'b0;
    #1 chk("R2 after edge", reg_rdata, 8'hA5);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 base low bits", v, 8'hFC);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 size high bits", v, 8'h0F);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 unused", v, 8'h00);
    rd(2'd0, v); chk("R2 ctrl unaffected", v, 8'hA5);

    // Sweep: program size x priority x general size code
    for (int sz = 0; sz < 4; sz++) begin
      for (int pr = 0; pr < 2; pr++) begin
        for (int code = 0; code < 8; code++) begin
          int  bf     = (sz * 23 + code * 11 + pr * 5) & 63;
          bit  pen    = (code != 3);
          bit  gen    = (code != 5);
          int  ion    = (code * 2 + pr + sz) & 15;
          bit  e1     = ion[3];
          bit  p1     = ion[2];
          bit  e2     = ion[1];
          bit  p2     = ion[0];
          int  eff    = (code > 6) ? 6 : code;
          int  win    = 1024 << eff;
          int  gstart = (bf * 1024) & ~(win - 1);
          int  pstart = 65536 - (65536 >> sz);
          wr(2'd0, {ion[3:0], pr[0], pen, sz[1:0]});
          wr(2'd1, {bf[5:0], 2'b00});
          wr(2'd2, {4'b0, gen, code[2:0]});
          for (int idx = 0; idx < 256; idx++) begin
            int off = (idx % 4 == 0) ? 0 : (idx % 4 == 3) ? 255 : ((idx * 37) & 255);
            int a   = idx * 256 + off;
            bit vld = (idx % 7) != 0;
            bit ph  = vld && pen && (a >= pstart);
            bit gh  = vld && gen && in_range(a, gstart, win);
            bit ep  = ph && !(gh && pr == 1);
            bit eg  = gh && !(ph && pr == 0);
            bit h1  = vld && in_range(a, int'(IO1_B), 1024);
            bit h2  = vld && in_range(a, int'(IO2_B), 1024);
            bit x1  = e1 ? (h1 ? p1 : !p1) : 1'b0;
            bit x2  = e2 ? (h2 ? p2 : !p2) : 1'b0;
            @(negedge clk);
            bus_addr  = a[15:0];
            bus_valid = vld;
            #1;
            chk("R3 R5 R8 cs_prog", {7'b0, cs_prog}, {7'b0, ep});
            chk("R4 R5 R8 cs_gp", {7'b0, cs_gp}, {7'b0, eg});
            chk("R6 R7 R8 io pins", {6'b0, cs_io2, cs_io1}, {6'b0, x2, x1});
            chk("R7 R9 pin own", {4'b0, prog_pin_own, gp_pin_own, io2_pin_own, io1_pin_own},
                {4'b0, pen, gen, e2, e1});
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule